// File: doc/BRIEF.md
# SIMD Lane Modular Adder/Subtractor

This block combines two wide operand words lane by lane. Each operand is split into unsigned elements. By default there are eight 32-bit lanes in a 256-bit word. Two control bits choose one of four operations: wrapping addition, wrapping subtraction, pseudo-modular addition and pseudo-modular subtraction.

The pseudo-modular forms apply one conditional correction with a modulus `q`. Every lane takes `q` from the lowest element of a separate modulus word. No carry or borrow ever passes from one lane to the next, and no flags are produced.

Operations enter through a valid/ready input handshake. Results leave through a one-entry registered output stage that also uses valid/ready. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result appears on `out_result`, with `out_valid` high, from the next cycle. A result is removed on an edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the result stays on the outputs and unchanged, and `in_ready` is low. When `out_ready` is high, a new request can be taken in the same cycle as the old result is removed, so the block sustains one operation per cycle.

Top module: `vma_vec_addsub`

## Requirements
- R1: Lane i of every operand word and of the result occupies bits [i*EW +: EW], so lane 0 is the least significant element.
- R2: With `in_op_sub`=0 and `in_op_mod`=0, each result lane is (a + b) mod 2^EW.
- R3: With `in_op_sub`=1 and `in_op_mod`=0, each result lane is (a - b) mod 2^EW.
- R4: Each lane's result depends only on that lane's operands and on `q`; no carry or borrow reaches a neighbouring lane.
- R5: With `in_op_sub`=0 and `in_op_mod`=1, let s = a + b computed without overflow. The lane result is (s - q) mod 2^EW when s >= q, and s mod 2^EW otherwise.
- R6: With `in_op_sub`=1 and `in_op_mod`=1, let d = a - b as a signed value. The lane result is (d + q) mod 2^EW when d < 0, and d otherwise.
- R7: `q` is bits [EW-1:0] of `in_modulus`; the upper bits of `in_modulus` have no effect on the result.
- R8: For the modular operations, when both a and b are below q the lane result is the true residue ((a+b) mod q or (a-b) mod q). A modular add with b = 0 maps any a in [0, 2q) to a mod q.
- R9: After a request is accepted, `out_valid` is high in the following cycle. A result stays stable on the outputs while `out_valid` is high and `out_ready` is low.
- R10: After reset, `out_valid` is low and `in_ready` is high.
- R11: `in_ready` is low exactly when a result is waiting and `out_ready` is low. A request offered while `in_ready` is low is not taken and does not change the held result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op_sub | input | 1 | 1 selects subtraction, 0 selects addition |
| in_op_mod | input | 1 | 1 selects the pseudo-modular form |
| in_a | input | LANES*EW | First operand vector |
| in_b | input | LANES*EW | Second operand vector (subtrahend) |
| in_modulus | input | LANES*EW | Modulus word; only the low EW bits are used |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | LANES*EW | Result vector |

## Verification
The bench builds the block with EW=4 and LANES=4. This makes the full cross product of a, b, q and all four operations small: 16384 requests, sent back to back at one per cycle. Every correction boundary can therefore be reached, including q=0, sums that overflow the element, and differences right at zero.

The three upper lanes carry operands derived from lane 0. This exposes any leak between lanes. The upper modulus bits change with every request, which shows that they have no effect. Directed sequences cover stalls on the output and requests offered while the block is not ready.

// File: rtl/vma_pkg.sv
package vma_pkg;
  typedef struct packed {
    logic sub;
    logic md;
  } vma_op_t;
endpackage

// File: rtl/vma_lane.sv
module vma_lane #(
  parameter int EW = 32
) (
  input  vma_pkg::vma_op_t op,
  input  logic [EW-1:0]    a,
  input  logic [EW-1:0]    b,
  input  logic [EW-1:0]    q,
  output logic [EW-1:0]    res
);
  localparam int XW = EW + 1;

  logic [XW-1:0] sum_x, dif_x, q_x;
  logic          sum_ge_q, dif_neg;
  logic [EW-1:0] add_fix, sub_fix;

  always_comb begin
    q_x      = {1'b0, q};
    sum_x    = {1'b0, a} + {1'b0, b};
    dif_x    = {1'b0, a} - {1'b0, b};
    dif_neg  = dif_x[EW];
    sum_ge_q = (sum_x >= q_x);
    add_fix  = sum_x[EW-1:0] - q;
    sub_fix  = dif_x[EW-1:0] + q;
    if (op.sub) begin
      res = (op.md && dif_neg) ? sub_fix : dif_x[EW-1:0];
    end else begin
      res = (op.md && sum_ge_q) ? add_fix : sum_x[EW-1:0];
    end
  end

  // R8: with both inputs inside [0,q), a modular result stays inside [0,q)
  always_comb begin
    if (op.md && !op.sub && (a < q) && (b < q)) begin
      a_r8_add_in_range: assert (res < q);
    end
    if (op.md && op.sub && (a < q) && (b < q)) begin
      a_r8_sub_in_range: assert (res < q);
    end
  end
endmodule

// File: rtl/vma_out_stage.sv
module vma_out_stage #(
  parameter int DW = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
    end else if (take) begin
      out_data <= in_data;
    end
  end

  // R9: an accepted request is presented in the next cycle
  a_r9_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R11: a stalled result is neither dropped nor overwritten
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/vma_vec_addsub.sv
module vma_vec_addsub #(
  parameter int EW    = 32,
  parameter int LANES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  in_op_sub,
  input  logic                  in_op_mod,
  input  logic [LANES*EW-1:0]   in_a,
  input  logic [LANES*EW-1:0]   in_b,
  input  logic [LANES*EW-1:0]   in_modulus,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [LANES*EW-1:0]   out_result
);
  localparam int VW = LANES * EW;

  vma_pkg::vma_op_t op;
  logic [EW-1:0]    q;
  logic [VW-1:0]    lane_res;

  assign op.sub = in_op_sub;
  assign op.md  = in_op_mod;
  assign q      = in_modulus[EW-1:0];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    vma_lane #(.EW(EW)) u_lane (
      .op  (op),
      .a   (in_a[i*EW +: EW]),
      .b   (in_b[i*EW +: EW]),
      .q   (q),
      .res (lane_res[i*EW +: EW])
    );
  end

  vma_out_stage #(.DW(VW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (lane_res),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_result)
  );
endmodule

// File: tb/vma_vec_addsub_test.sv
module vma_vec_addsub_test;
  localparam int CLK_P = 10;
  localparam int EW    = 4;
  localparam int LN    = 4;
  localparam int W     = EW * LN;
  localparam int EMAX  = (1 << EW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_op_sub = 1'b0, in_op_mod = 1'b0;
  logic [W-1:0] in_a = '0, in_b = '0, in_modulus = '0;
  logic out_valid, out_ready = 1'b1;
  logic [W-1:0] out_result;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  vma_vec_addsub #(.EW(EW), .LANES(LN)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op_sub(in_op_sub), .in_op_mod(in_op_mod), .in_a(in_a), .in_b(in_b),
    .in_modulus(in_modulus), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result)
  );

  function automatic int ref_lane(int a, int b, int q, bit sub, bit md);
    int s;
    s = sub ? (a - b) : (a + b);
    if (md && !sub && s >= q) s = s - q;
    if (md && sub && s < 0) s = s + q;
    return s & EMAX;
  endfunction

  task automatic check(bit ok, string tag, int got, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // pending expectation for the request sent in the previous cycle
  bit pend = 0;
  bit pend_r8 = 0;
  int pend_r8_val = 0;
  int pend_lane [LN];
  string pend_tag = "";

  task automatic check_pending();
    check(out_valid === 1'b1, "R9 valid after accept", int'(out_valid), 1);
    for (int k = 0; k < LN; k++) begin
      int got;
      got = int'(out_result[k*EW +: EW]);
      check(got == pend_lane[k], (k == 0) ? pend_tag : "R4 lane isolation", got, pend_lane[k]);
    end
    if (pend_r8) begin
      int g0;
      g0 = int'(out_result[EW-1:0]);
      check(g0 == pend_r8_val, "R8 true residue", g0, pend_r8_val);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(out_valid === 1'b0, "R10 out_valid low in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R10 out_valid low after reset", int'(out_valid), 0);
    check(in_ready === 1'b1, "R10 in_ready high after reset", int'(in_ready), 1);

    // exhaustive sweep, one request per cycle
    for (int op = 0; op < 4; op++) begin
      for (int q = 0; q <= EMAX; q++) begin
        for (int a = 0; a <= EMAX; a++) begin
          for (int b = 0; b <= EMAX; b++) begin
            bit sub, md;
            int la [LN];
            int lb [LN];
            sub = op[1];
            md  = op[0];
            la[0] = a;        lb[0] = b;
            la[1] = b;        lb[1] = a;
            la[2] = EMAX - a; lb[2] = b;
            la[3] = a ^ b;    lb[3] = EMAX - b;
            @(negedge clk);
            if (pend) check_pending();
            in_valid  = 1'b1;
            in_op_sub = sub;
            in_op_mod = md;
            for (int k = 0; k < LN; k++) begin
              in_a[k*EW +: EW] = EW'(la[k]);
              in_b[k*EW +: EW] = EW'(lb[k]);
              pend_lane[k] = ref_lane(la[k], lb[k], q, sub, md);
            end
            // R7: upper modulus bits change with every request
            in_modulus = {EW'(a ^ q), EW'(b), EW'(EMAX - q), EW'(q)};
            pend_tag = (op == 0) ? "R2 plain add" : (op == 2) ? "R3 plain sub" :
                       (op == 1) ? "R5 modular add R7" : "R6 modular sub R7";
            pend_r8 = 0;
            if (md && q > 0 && a < q && b < q) begin
              pend_r8 = 1;
              pend_r8_val = sub ? (((a - b) % q) + q) % q : (a + b) % q;
            end else if (md && !sub && q > 0 && b == 0 && a < 2 * q) begin
              pend_r8 = 1;
              pend_r8_val = a % q;
            end
            pend = 1;
          end
        end
      end
    end
    @(negedge clk);
    check_pending();
    pend = 0;
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0, "R9 valid drops when drained", int'(out_valid), 0);

    // R1: lane ordering, plain add with b = 0 returns a unchanged
    in_valid = 1'b1; in_op_sub = 1'b0; in_op_mod = 1'b0;
    in_a = 16'h3A71; in_b = '0; in_modulus = '0;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_result[EW-1:0] == 4'h1, "R1 lane 0 in low bits", int'(out_result[EW-1:0]), 1);
    check(out_result == 16'h3A71, "R1 lane order", int'(out_result), 16'h3A71);

    // R7: modular add 9+9 with q=5 gives 13 regardless of upper modulus bits
    in_valid = 1'b1; in_op_mod = 1'b1;
    in_a = 16'h0009; in_b = 16'h0009; in_modulus = 16'hFFF5;
    @(negedge clk);
    check(out_result[EW-1:0] == 4'd13, "R7 upper bits set", int'(out_result[EW-1:0]), 13);
    in_modulus = 16'h0005;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_result[EW-1:0] == 4'd13, "R7 upper bits clear", int'(out_result[EW-1:0]), 13);

    // R9 and R11: output stall and refused input
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op_sub = 1'b0; in_op_mod = 1'b0;
    in_a = 16'h1111; in_b = 16'h2222; in_modulus = '0;
    @(negedge clk);
    check(out_result == 16'h3333, "R9 stalled result", int'(out_result), 16'h3333);
    check(in_ready === 1'b0, "R11 not ready while stalled", int'(in_ready), 0);
    in_a = 16'h4444; in_b = 16'h1111;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(out_valid === 1'b1 && out_result == 16'h3333, "R11 refused request ignored",
            int'(out_result), 16'h3333);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1 && out_result == 16'h5555, "R11 request taken on release",
          int'(out_result), 16'h5555);
    @(negedge clk);
    check(out_valid === 1'b0, "R9 valid drops after drain", int'(out_valid), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule